// File: doc/BRIEF.md
# 1-Wire Active and Strong Pullup Controller

This block decides, cycle by cycle, when the low-impedance pullup transistor on a 1-Wire line conducts. It sits beside the slot timing engine and takes that engine's phase strobes: the end of the reset low time, the expiry of the reset high time, the end of a slot's master low phase, the end of a slot, and a flag marking the final slot of a command. It also takes a synchronised comparator output that is high once the line is above the active-pullup threshold. It drives a single pullup enable.

In active-pullup mode the controller arms after each master low phase and fires on the next upward threshold crossing. Inside a reset cycle the first firing is timed: the on time is 2.5 µs at standard speed or 0.5 µs at overdrive, converted to clock cycles. The trigger then re-arms for the edge that ends the presence pulse and holds until the reset high time expires. Inside a slot a firing holds until the slot ends.

In strong-pullup mode, which the host arms before a command, the firing in the command's final slot latches on. It stays on until the next traffic-generating command, a host disable or a master reset. The strong-pullup arm then clears itself, and the active-pullup enable is left as it was. The pulldown always wins over the pullup.

Top module: `ow_pullup_ctrl`

## Requirements
- R1: While and after the synchronous reset `rst`, `pu_en` is 0 until a new firing.
- R2: In a reset cycle with `apu_en`=1, an upward crossing before `rst_low_end` does not fire. The first crossing after it turns `pu_en` on.
- R3: At standard speed (`speed_od`=0, sampled at the firing), the first reset-cycle firing keeps `pu_en` high for exactly APU_NS_STD*CLK_MHZ/1000 clock cycles, which is 312 by default.
- R4: At overdrive (`speed_od`=1) that timed on time is APU_NS_OD*CLK_MHZ/1000 cycles, which is 62 by default.
- R5: After the timed on time the trigger re-arms. The next upward crossing, which ends the presence pulse, turns `pu_en` on, and it stays on until the cycle after `rst_high_end`.
- R6: In a slot with `apu_en`=1, the first upward crossing after `slot_low_end` turns `pu_en` on. It stays on until the cycle after `slot_end`.
- R7: Outside an armed reset cycle or slot, or with `apu_en`=0 and no strong pullup armed, upward crossings leave `pu_en` at 0.
- R8: After a pulse on `spu_arm`, the crossing in a slot marked `last_slot`=1 turns `pu_en` on even when `apu_en`=0. It stays on past `slot_end`.
- R9: An active strong pullup ends, with `pu_en`=0 the next cycle, on `cmd_start`, `spu_disable` or `mst_rst`. The arm is then cleared, so a later final slot with `apu_en`=0 does not fire.
- R10: The strong pullup does not alter the active-pullup setting. With `apu_en`=1 and no arm pending, a final slot still releases the pullup at `slot_end`.
- R11: In any cycle where `pd_en` is 1, `pu_en` is 0. When `pd_en` drops during a hold phase, the pullup resumes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| speed_od | input | 1 | 1 = overdrive timing, 0 = standard |
| rst_low_end | input | 1 | Strobe: reset low time has ended |
| rst_high_end | input | 1 | Strobe: reset high time has expired |
| slot_low_end | input | 1 | Strobe: master low phase of a slot has ended |
| last_slot | input | 1 | Current slot is the final slot of a command |
| slot_end | input | 1 | Strobe: slot (including recovery) has ended |
| line_hi | input | 1 | Comparator: line is above the pullup threshold |
| pd_en | input | 1 | Master pulldown is driving the line low |
| apu_en | input | 1 | Active pullup enabled by the host |
| spu_arm | input | 1 | Strobe: host arms a strong pullup |
| spu_disable | input | 1 | Strobe: host cancels the strong pullup |
| cmd_start | input | 1 | Strobe: new command with 1-Wire traffic begins |
| mst_rst | input | 1 | Strobe: 1-Wire master reset |
| pu_en | output | 1 | Pullup transistor enable |

## Verification
The main function is tried with four threshold patterns. The first is a crossing before the reset low time ends, which separates a true arm from a level-sensitive trigger. The second is a full reset cycle with a presence dip at both speeds, which separates the timed firing, the re-arm and the hold to reset-high expiry. The third is a slot with one crossing, which shows that release follows `slot_end`. The fourth is a crossing with nothing armed, which shows that the trigger stays confined to its windows. The strong-pullup runs end once by each of the three terminating events. Each is followed by a final slot with the active pullup disabled, which tells a self-cleared arm apart from a sticky one. A pulldown pulse inside a hold checks the priority of the pulldown.

// File: rtl/ow_pu_pkg.sv
package ow_pu_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_R_ARM,
    ST_R_TIMED,
    ST_R_REARM,
    ST_R_HOLD,
    ST_S_ARM,
    ST_S_HOLD,
    ST_STRONG
  } pu_state_e;

  function automatic logic pu_drives(input pu_state_e s);
    return (s == ST_R_TIMED) || (s == ST_R_HOLD) ||
           (s == ST_S_HOLD) || (s == ST_STRONG);
  endfunction
endpackage

// File: rtl/ow_pu_rise.sv
module ow_pu_rise #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic line_hi,
  output logic rise
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= line_hi;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= {sync_q[STAGES-2:0], line_hi};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= sync_q[STAGES-1];
  end

  assign rise = sync_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/ow_pu_timer.sv
module ow_pu_timer #(
  parameter int STD_CYC = 312,
  parameter int OD_CYC  = 62,
  localparam int CW = $clog2(STD_CYC + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic od,
  output logic done
);
  localparam logic [CW-1:0] STD_LD = CW'(STD_CYC - 1);
  localparam logic [CW-1:0] OD_LD  = CW'(OD_CYC - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)               cnt_q <= '0;
    else if (load)         cnt_q <= od ? OD_LD : STD_LD;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign done = (cnt_q == '0);
endmodule

// File: rtl/ow_pu_strong.sv
module ow_pu_strong (
  input  logic clk,
  input  logic rst,
  input  logic arm,
  input  logic cancel,
  input  logic consume,
  output logic armed
);
  always_ff @(posedge clk) begin
    if (rst || cancel || consume) armed <= 1'b0;
    else if (arm)                 armed <= 1'b1;
  end
endmodule

// File: rtl/ow_pullup_ctrl.sv
module ow_pullup_ctrl
  import ow_pu_pkg::*;
#(
  parameter int CLK_MHZ     = 125,
  parameter int APU_NS_STD  = 2500,
  parameter int APU_NS_OD   = 500,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic speed_od,
  input  logic rst_low_end,
  input  logic rst_high_end,
  input  logic slot_low_end,
  input  logic last_slot,
  input  logic slot_end,
  input  logic line_hi,
  input  logic pd_en,
  input  logic apu_en,
  input  logic spu_arm,
  input  logic spu_disable,
  input  logic cmd_start,
  input  logic mst_rst,
  output logic pu_en
);
  localparam int STD_CYC = (APU_NS_STD * CLK_MHZ) / 1000;
  localparam int OD_CYC  = (APU_NS_OD * CLK_MHZ) / 1000;

  pu_state_e st_q, st_d;
  logic      rise, tmr_load, tmr_done;
  logic      spu_armed, spu_pend, spu_consume;
  logic      strong_q, pu_q;

  ow_pu_rise #(.STAGES(SYNC_STAGES)) u_rise (
    .clk(clk), .rst(rst), .line_hi(line_hi), .rise(rise)
  );

  ow_pu_timer #(.STD_CYC(STD_CYC), .OD_CYC(OD_CYC)) u_tmr (
    .clk(clk), .rst(rst), .load(tmr_load), .od(speed_od), .done(tmr_done)
  );

  assign spu_pend    = spu_armed & last_slot;
  assign spu_consume = (st_q == ST_STRONG) && (st_d != ST_STRONG);

  ow_pu_strong u_spu (
    .clk(clk), .rst(rst), .arm(spu_arm), .cancel(spu_disable | mst_rst),
    .consume(spu_consume), .armed(spu_armed)
  );

  always_comb begin
    st_d     = st_q;
    tmr_load = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (rst_low_end && apu_en)                   st_d = ST_R_ARM;
        else if (slot_low_end && (apu_en || spu_pend)) st_d = ST_S_ARM;
      end
      ST_R_ARM: begin
        if (rst_high_end) st_d = ST_IDLE;
        else if (rise) begin
          st_d     = ST_R_TIMED;
          tmr_load = 1'b1;
        end
      end
      ST_R_TIMED: begin
        if (rst_high_end)  st_d = ST_IDLE;
        else if (tmr_done) st_d = ST_R_REARM;
      end
      ST_R_REARM: begin
        if (rst_high_end) st_d = ST_IDLE;
        else if (rise)    st_d = ST_R_HOLD;
      end
      ST_R_HOLD: if (rst_high_end) st_d = ST_IDLE;
      ST_S_ARM: begin
        if (slot_end)  st_d = ST_IDLE;
        else if (rise) st_d = strong_q ? ST_STRONG : ST_S_HOLD;
      end
      ST_S_HOLD: if (slot_end) st_d = ST_IDLE;
      ST_STRONG: if (cmd_start || spu_disable) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
    if (mst_rst) st_d = ST_IDLE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= ST_IDLE;
      strong_q <= 1'b0;
      pu_q     <= 1'b0;
    end else begin
      st_q <= st_d;
      pu_q <= pu_drives(st_d);
      if (st_q == ST_IDLE && st_d == ST_S_ARM) strong_q <= spu_pend;
      else if (st_d == ST_IDLE)                strong_q <= 1'b0;
    end
  end

  assign pu_en = pu_q & ~pd_en;
endmodule

// File: rtl/ow_pullup_ctrl_chk.sv
module ow_pullup_ctrl_chk
  import ow_pu_pkg::*;
(
  input logic      clk,
  input logic      rst,
  input logic      pd_en,
  input logic      pu_en,
  input logic      pu_q,
  input pu_state_e st_q,
  input logic      rst_high_end,
  input logic      slot_end,
  input logic      cmd_start,
  input logic      spu_disable,
  input logic      mst_rst
);
  p_reset_off_r1: assert property (@(posedge clk) rst |=> !pu_q);

  p_pd_wins_r11: assert property (@(posedge clk) disable iff (rst)
    pd_en |-> !pu_en);

  p_fire_armed_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(pu_q) |-> ($past(st_q) == ST_R_ARM || $past(st_q) == ST_R_REARM ||
                     $past(st_q) == ST_S_ARM));

  p_rst_release_r5: assert property (@(posedge clk) disable iff (rst)
    (rst_high_end && (st_q == ST_R_TIMED || st_q == ST_R_HOLD)) |=> !pu_q);

  p_slot_release_r6: assert property (@(posedge clk) disable iff (rst)
    (slot_end && st_q == ST_S_HOLD) |=> !pu_q);

  p_strong_stop_r9: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_STRONG && (cmd_start || spu_disable)) |=> !pu_q);

  p_master_reset_r9: assert property (@(posedge clk) disable iff (rst)
    mst_rst |=> !pu_q);
endmodule

bind ow_pullup_ctrl ow_pullup_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .pd_en(pd_en), .pu_en(pu_en), .pu_q(pu_q),
  .st_q(st_q), .rst_high_end(rst_high_end), .slot_end(slot_end),
  .cmd_start(cmd_start), .spu_disable(spu_disable), .mst_rst(mst_rst)
);

// File: tb/ow_pullup_ctrl_tb.sv
module ow_pullup_ctrl_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic speed_od = 0, rst_low_end = 0, rst_high_end = 0, slot_low_end = 0;
  logic last_slot = 0, slot_end = 0, line_hi = 0, pd_en = 0, apu_en = 0;
  logic spu_arm = 0, spu_disable = 0, cmd_start = 0, mst_rst = 0;
  logic pu_en;

  int total = 0;
  int bad   = 0;

  always #4 clk = ~clk;

  ow_pullup_ctrl u_dut (
    .clk(clk), .rst(rst), .speed_od(speed_od), .rst_low_end(rst_low_end),
    .rst_high_end(rst_high_end), .slot_low_end(slot_low_end),
    .last_slot(last_slot), .slot_end(slot_end), .line_hi(line_hi),
    .pd_en(pd_en), .apu_en(apu_en), .spu_arm(spu_arm),
    .spu_disable(spu_disable), .cmd_start(cmd_start), .mst_rst(mst_rst),
    .pu_en(pu_en)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // one-cycle strobe helpers
  task automatic strobe_rle();  rst_low_end  = 1; step(1); rst_low_end  = 0; endtask
  task automatic strobe_rhe();  rst_high_end = 1; step(1); rst_high_end = 0; endtask
  task automatic strobe_sle();  slot_low_end = 1; step(1); slot_low_end = 0; endtask
  task automatic strobe_se();   slot_end     = 1; step(1); slot_end     = 0; endtask
  task automatic strobe_arm();  spu_arm      = 1; step(1); spu_arm      = 0; endtask
  task automatic strobe_dis();  spu_disable  = 1; step(1); spu_disable  = 0; endtask
  task automatic strobe_cmd();  cmd_start    = 1; step(1); cmd_start    = 0; endtask
  task automatic strobe_mrst(); mst_rst      = 1; step(1); mst_rst      = 0; endtask

  task automatic line_rise();
    line_hi = 0; step(4); line_hi = 1; step(5);
  endtask

  task automatic t_reset_state();
    step(1);
    check("R1 reset", pu_en, 0);
  endtask

  task automatic t_reset_cycle(input logic od, input int exp_cyc, input string req);
    int cnt;
    apu_en = 1; speed_od = od;
    line_hi = 0; step(2);
    line_hi = 1; step(5);
    check("R2 no fire before reset low end", pu_en, 0);
    line_hi = 0; step(2);
    strobe_rle();
    check("R2 armed not yet on", pu_en, 0);
    line_hi = 1;
    cnt = 0;
    for (int i = 0; i < 500; i++) begin
      step(1);
      if (pu_en) cnt++;
    end
    check(req, cnt, exp_cyc);
    line_hi = 0; step(6);
    line_hi = 1; step(5);
    check("R5 presence end fires", pu_en, 1);
    step(40);
    check("R5 held until reset high end", pu_en, 1);
    strobe_rhe();
    check("R5 released after reset high end", pu_en, 0);
  endtask

  task automatic t_slot();
    apu_en = 1; speed_od = 0; line_hi = 0; step(2);
    strobe_sle();
    line_rise();
    check("R6 slot fires", pu_en, 1);
    step(30);
    check("R6 slot held", pu_en, 1);
    pd_en = 1; step(1);
    check("R11 pulldown wins", pu_en, 0);
    pd_en = 0; step(1);
    check("R11 pullup resumes", pu_en, 1);
    strobe_se();
    check("R6 released at slot end", pu_en, 0);
  endtask

  task automatic t_outside();
    int seen;
    apu_en = 1; seen = 0;
    line_hi = 0; step(3); line_hi = 1;
    for (int i = 0; i < 8; i++) begin step(1); if (pu_en) seen++; end
    check("R7 no fire when unarmed", seen, 0);
    apu_en = 0; line_hi = 0; step(2);
    strobe_rle();
    line_rise();
    check("R7 no fire with apu off (reset)", pu_en, 0);
    strobe_rhe();
    strobe_sle();
    line_rise();
    check("R7 no fire with apu off (slot)", pu_en, 0);
    strobe_se();
  endtask

  task automatic strong_start();
    apu_en = 0; line_hi = 0; step(2);
    strobe_arm();
    last_slot = 1;
    strobe_sle();
    line_rise();
    check("R8 strong fires with apu off", pu_en, 1);
    strobe_se();
    last_slot = 0;
    step(20);
    check("R8 strong held past slot end", pu_en, 1);
  endtask

  task automatic strong_self_clear(input string req);
    apu_en = 0; last_slot = 1; line_hi = 0; step(2);
    strobe_sle();
    line_rise();
    check(req, pu_en, 0);
    strobe_se();
    last_slot = 0;
  endtask

  task automatic t_strong();
    strong_start();
    strobe_cmd();
    check("R9 cmd_start ends strong", pu_en, 0);
    strong_self_clear("R9 arm cleared after cmd_start");
    strong_start();
    strobe_dis();
    check("R9 disable ends strong", pu_en, 0);
    strong_self_clear("R9 arm cleared after disable");
    strong_start();
    strobe_mrst();
    check("R9 master reset ends strong", pu_en, 0);
    strong_self_clear("R9 arm cleared after master reset");
  endtask

  task automatic t_apu_kept();
    apu_en = 1; last_slot = 1; line_hi = 0; step(2);
    strobe_sle();
    line_rise();
    check("R10 apu still fires in final slot", pu_en, 1);
    strobe_se();
    check("R10 final slot released at slot end", pu_en, 0);
    last_slot = 0;
  endtask

  initial begin
    step(3);
    check("R1 during reset", pu_en, 0);
    rst = 0;
    t_reset_state();
    t_reset_cycle(1'b0, 312, "R3 standard on time");
    t_reset_cycle(1'b1, 62, "R4 overdrive on time");
    t_slot();
    t_outside();
    t_strong();
    t_apu_kept();
    step(2);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 150000);
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule